// File: doc/BRIEF.md
# Neighbourhood Connectivity Label Core

This block is the per-pixel labelling core of one processing element in a row-parallel connected-component labeller. The pixels of one image row stream into it, one per clock. A neighbouring element streams in the finished values and labels of the adjacent row. For each pixel the core decides which of its four causal neighbours belong to the same region. It then produces the pixel's label and, when two differently labelled regions meet, an equivalence record for the external equivalence table.

Connectivity depends on exact equality of pixel values, so binary and gray-level images are handled alike. The adjacent row is the row above during a forward labelling pass and the row below during a backward pass. In the forward pass, a pixel that joins no existing region is given a label derived from its position. In the backward pass, such a pixel takes the resolved minimum that the external table supplies for its existing label. Labels of value zero mean "unlabelled".

The adjacent-row stream runs two columns ahead of the pixel stream. The element for column c+1 is accepted one cycle before pixel c. A three-deep window inside the core therefore presents columns c+1, c and c-1 of the adjacent row when pixel c arrives. The left neighbour comes from the core's own output register.

Top module: `nbr_label_core`

## Requirements
- R1: After reset, outValid and eqValid are low.
- R2: Every clock with pixValid high produces exactly one result, with outValid high in the following cycle. With pixValid low, outValid is low in the following cycle.
- R3: A neighbour is a candidate only when its pixel value equals pixValue exactly and its label is nonzero. Neighbours with a different value or a zero label have no effect on the result.
- R4: With passSel=0 captured for the row, a pixel with no candidate gets the fresh label (row+1)*COLS + (col+1), where row is the captured rowIndex and col is the 0-based column.
- R5: With passSel=1 captured for the row, a pixel with no candidate gets lookupLabel as its label.
- R6: A pixel with at least one candidate gets the smallest candidate label, whichever pass is active.
- R7: When the candidates carry at least two different labels, eqValid is high together with the result, with eqOld the largest and eqNew the smallest candidate label. Otherwise eqValid is low.
- R8: At column 0 the upper/lower-left and left neighbours are excluded. At column COLS-1 the upper/lower-right neighbour is excluded.
- R9: All three adjacent-row neighbours are excluded on row 0 in a forward pass (passSel=0) and on row ROWS-1 in a backward pass (passSel=1).
- R10: rowIndex and passSel are captured only in the cycle where rowStart is high, together with the pixel of column 0. Later pixels of the row count columns 1, 2, … from consecutive pixValid cycles and ignore those inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowStart | input | 1 | Marks the column-0 pixel; captures rowIndex and passSel |
| rowIndex | input | $clog2(ROWS) | 0-based row number of the row being started |
| passSel | input | 1 | 0: forward pass with fresh labels; 1: backward pass with table lookup |
| adjValue | input | VAL_W | Adjacent-row pixel value, two columns ahead of the pixel stream |
| adjLabel | input | LABEL_W | Adjacent-row label matching adjValue |
| pixValid | input | 1 | A current-row pixel is present |
| pixValue | input | VAL_W | Current pixel value |
| lookupLabel | input | LABEL_W | Resolved table minimum for the pixel's existing label (backward pass) |
| outValid | output | 1 | Result of the previous cycle's pixel is present |
| outLabel | output | LABEL_W | Label assigned to that pixel |
| eqValid | output | 1 | A merge produced an equivalence record |
| eqOld | output | LABEL_W | Record's old (larger) label |
| eqNew | output | LABEL_W | Record's new (smaller) label |

## Verification
The bench sweeps both passes over the first, last and interior rows. It uses dense gray-level patterns with few distinct values, zero labels and adversarial adjacent data on edge rows and columns. An off-by-one in the skew window would pair a pixel with the wrong upper column and produce wrong minima. Missing edge masking would let garbage beyond column COLS-1 or from a non-existent row merge into real regions. An inverted maximum/minimum would swap the two fields of the equivalence record. Failing to capture the row context on rowStart alone would corrupt the fresh labels and the pass rule, because the bench drives a different row number and the opposite pass on every other pixel of the row.

// File: rtl/nbr_label_pkg.sv
package nbr_label_pkg;

  // Strobes handed from the row control to the label datapath each cycle.
  typedef struct packed {
    logic accept;     // a current-row pixel is taken this cycle
    logic leftOk;     // column has a left-side neighbour column
    logic rightOk;    // column has a right-side neighbour column
    logic adjOk;      // adjacent row exists for this pass
    logic useLookup;  // no-candidate rule: table lookup instead of fresh label
  } nbrStrobe_t;

  // Slots of the causal neighbourhood.
  typedef enum logic [1:0] {
    NB_DIAG_L = 2'd0,   // adjacent row, column c-1
    NB_VERT   = 2'd1,   // adjacent row, column c
    NB_DIAG_R = 2'd2,   // adjacent row, column c+1
    NB_LEFT   = 2'd3    // same row, column c-1
  } nbrSlot_e;

  localparam int NB_COUNT = 4;

endpackage

// File: rtl/nbr_label_ctrl.sv
module nbr_label_ctrl
  import nbr_label_pkg::*;
#(
  parameter int COLS    = 8,
  parameter int ROWS    = 8,
  parameter int LABEL_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rowStart,
  input  logic [$clog2(ROWS)-1:0] rowIndex,
  input  logic                    passSel,
  input  logic                    pixValid,
  output nbrStrobe_t              strobe,
  output logic [LABEL_W-1:0]      freshLabel
);

  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic [COL_W-1:0] colCount;
  logic [ROW_W-1:0] rowReg;
  logic             passReg;

  logic [COL_W-1:0] curCol;
  logic [ROW_W-1:0] curRow;
  logic             curPass;
  logic             edgeRow;

  // Row context is live on the rowStart cycle, held afterwards.
  assign curCol  = rowStart ? '0       : colCount;
  assign curRow  = rowStart ? rowIndex : rowReg;
  assign curPass = rowStart ? passSel  : passReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCount <= '0;
      rowReg   <= '0;
      passReg  <= 1'b0;
    end else begin
      if (pixValid) colCount <= curCol + 1'b1;
      if (rowStart) begin
        rowReg  <= rowIndex;
        passReg <= passSel;
      end
    end
  end

  // Forward pass has no row above row 0; backward pass none below the last row.
  assign edgeRow = curPass ? (curRow == ROW_W'(ROWS - 1)) : (curRow == '0);

  always_comb begin
    strobe.accept    = pixValid;
    strobe.leftOk    = (curCol != '0);
    strobe.rightOk   = (curCol != COL_W'(COLS - 1));
    strobe.adjOk     = !edgeRow;
    strobe.useLookup = curPass;
  end

  // Position-derived label with 1-based coordinates, never zero.
  assign freshLabel = LABEL_W'((int'(curRow) + 1) * COLS + int'(curCol) + 1);

endmodule

// File: rtl/nbr_label_dp.sv
module nbr_label_dp
  import nbr_label_pkg::*;
#(
  parameter int VAL_W   = 4,
  parameter int LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  nbrStrobe_t         strobe,
  input  logic [LABEL_W-1:0] freshLabel,
  input  logic [VAL_W-1:0]   adjValue,
  input  logic [LABEL_W-1:0] adjLabel,
  input  logic [VAL_W-1:0]   pixValue,
  input  logic [LABEL_W-1:0] lookupLabel,
  output logic               outValid,
  output logic [LABEL_W-1:0] outLabel,
  output logic               eqValid,
  output logic [LABEL_W-1:0] eqOld,
  output logic [LABEL_W-1:0] eqNew
);

  localparam int WIN = 3;

  // Skew window over the adjacent row: [0]=c+1, [1]=c, [2]=c-1.
  logic [VAL_W-1:0]   winVal [WIN];
  logic [LABEL_W-1:0] winLbl [WIN];
  logic [VAL_W-1:0]   leftVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN; i++) begin
        winVal[i] <= '0;
        winLbl[i] <= '0;
      end
    end else begin
      winVal[0] <= adjValue;
      winLbl[0] <= adjLabel;
      for (int i = 1; i < WIN; i++) begin
        winVal[i] <= winVal[i-1];
        winLbl[i] <= winLbl[i-1];
      end
    end
  end

  logic [VAL_W-1:0]    nbVal [NB_COUNT];
  logic [LABEL_W-1:0]  nbLbl [NB_COUNT];
  logic [NB_COUNT-1:0] nbOk;
  logic [NB_COUNT-1:0] cand;

  assign nbVal[NB_DIAG_L] = winVal[2];
  assign nbVal[NB_VERT]   = winVal[1];
  assign nbVal[NB_DIAG_R] = winVal[0];
  assign nbVal[NB_LEFT]   = leftVal;
  assign nbLbl[NB_DIAG_L] = winLbl[2];
  assign nbLbl[NB_VERT]   = winLbl[1];
  assign nbLbl[NB_DIAG_R] = winLbl[0];
  assign nbLbl[NB_LEFT]   = outLabel;

  assign nbOk[NB_DIAG_L] = strobe.adjOk && strobe.leftOk;
  assign nbOk[NB_VERT]   = strobe.adjOk;
  assign nbOk[NB_DIAG_R] = strobe.adjOk && strobe.rightOk;
  assign nbOk[NB_LEFT]   = strobe.leftOk;

  // One equality comparator per neighbour slot.
  for (genvar g = 0; g < NB_COUNT; g++) begin : gCmp
    assign cand[g] = nbOk[g] && (nbVal[g] == pixValue) && (nbLbl[g] != '0);
  end

  logic               noneMatch;
  logic [LABEL_W-1:0] minLbl;
  logic [LABEL_W-1:0] maxLbl;
  logic [LABEL_W-1:0] nextLabel;
  logic               merge;

  assign noneMatch = ~|cand;

  always_comb begin
    minLbl = '1;
    maxLbl = '0;
    for (int i = 0; i < NB_COUNT; i++) begin
      if (cand[i]) begin
        if (nbLbl[i] < minLbl) minLbl = nbLbl[i];
        if (nbLbl[i] > maxLbl) maxLbl = nbLbl[i];
      end
    end
  end

  always_comb begin
    if (noneMatch) nextLabel = strobe.useLookup ? lookupLabel : freshLabel;
    else           nextLabel = minLbl;
  end

  assign merge = !noneMatch && (maxLbl != minLbl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLabel <= '0;
      leftVal  <= '0;
      eqValid  <= 1'b0;
      eqOld    <= '0;
      eqNew    <= '0;
    end else begin
      outValid <= strobe.accept;
      eqValid  <= strobe.accept && merge;
      if (strobe.accept) begin
        outLabel <= nextLabel;
        leftVal  <= pixValue;
        eqOld    <= maxLbl;
        eqNew    <= minLbl;
      end
    end
  end

endmodule

// File: rtl/nbr_label_core.sv
module nbr_label_core
  import nbr_label_pkg::*;
#(
  parameter int COLS    = 8,
  parameter int ROWS    = 8,
  parameter int VAL_W   = 4,
  parameter int LABEL_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rowStart,
  input  logic [$clog2(ROWS)-1:0] rowIndex,
  input  logic                    passSel,
  input  logic [VAL_W-1:0]        adjValue,
  input  logic [LABEL_W-1:0]      adjLabel,
  input  logic                    pixValid,
  input  logic [VAL_W-1:0]        pixValue,
  input  logic [LABEL_W-1:0]      lookupLabel,
  output logic                    outValid,
  output logic [LABEL_W-1:0]      outLabel,
  output logic                    eqValid,
  output logic [LABEL_W-1:0]      eqOld,
  output logic [LABEL_W-1:0]      eqNew
);

  nbrStrobe_t         strobe;
  logic [LABEL_W-1:0] freshLabel;

  nbr_label_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .LABEL_W(LABEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rowStart(rowStart), .rowIndex(rowIndex),
    .passSel(passSel), .pixValid(pixValid),
    .strobe(strobe), .freshLabel(freshLabel)
  );

  nbr_label_dp #(
    .VAL_W(VAL_W), .LABEL_W(LABEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .freshLabel(freshLabel),
    .adjValue(adjValue), .adjLabel(adjLabel), .pixValue(pixValue),
    .lookupLabel(lookupLabel),
    .outValid(outValid), .outLabel(outLabel),
    .eqValid(eqValid), .eqOld(eqOld), .eqNew(eqNew)
  );

endmodule

// File: rtl/nbr_label_checker.sv
module nbr_label_checker #(
  parameter int LABEL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               pixValid,
  input logic               outValid,
  input logic [LABEL_W-1:0] outLabel,
  input logic               eqValid,
  input logic [LABEL_W-1:0] eqOld,
  input logic [LABEL_W-1:0] eqNew
);

  // R2
  result_follows_pixel_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  // R2
  no_result_without_pixel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  // R7
  record_with_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    eqValid |-> outValid);

  // R7
  record_ordered_chk: assert property (@(posedge clk) disable iff (!rstN)
    eqValid |-> (eqNew < eqOld));

  // R6
  label_is_record_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    eqValid |-> (outLabel == eqNew));

endmodule

bind nbr_label_core nbr_label_checker #(.LABEL_W(LABEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .outValid(outValid),
  .outLabel(outLabel), .eqValid(eqValid), .eqOld(eqOld), .eqNew(eqNew)
);

// File: tb/nbr_label_core_bench.sv
`timescale 1ns/1ps
module nbr_label_core_bench;

  localparam int COLS    = 8;
  localparam int ROWS    = 8;
  localparam int VAL_W   = 4;
  localparam int LABEL_W = 8;

  logic               clk = 1'b0;
  logic               rstN;
  logic               rowStart;
  logic [2:0]         rowIndex;
  logic               passSel;
  logic [VAL_W-1:0]   adjValue;
  logic [LABEL_W-1:0] adjLabel;
  logic               pixValid;
  logic [VAL_W-1:0]   pixValue;
  logic [LABEL_W-1:0] lookupLabel;
  logic               outValid;
  logic [LABEL_W-1:0] outLabel;
  logic               eqValid;
  logic [LABEL_W-1:0] eqOld;
  logic [LABEL_W-1:0] eqNew;

  always #5 clk = ~clk;

  nbr_label_core #(
    .COLS(COLS), .ROWS(ROWS), .VAL_W(VAL_W), .LABEL_W(LABEL_W)
  ) u_nbr_label_core (
    .clk(clk), .rstN(rstN), .rowStart(rowStart), .rowIndex(rowIndex),
    .passSel(passSel), .adjValue(adjValue), .adjLabel(adjLabel),
    .pixValid(pixValid), .pixValue(pixValue), .lookupLabel(lookupLabel),
    .outValid(outValid), .outLabel(outLabel), .eqValid(eqValid),
    .eqOld(eqOld), .eqNew(eqNew)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  int adjV [COLS];
  int adjL [COLS];
  int curV [COLS];
  int lkp  [COLS];
  int expL [COLS];
  int expEq[COLS];
  int expO [COLS];
  int expN [COLS];
  string expTag [COLS];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]) % m;
  endfunction

  // Reference from the requirements: candidates, minimum, fresh/lookup, record.
  function automatic void model(input int pass, input int r);
    bit adjOk = (pass == 0) ? (r != 0) : (r != ROWS - 1);
    for (int x = 0; x < COLS; x++) begin
      int cv [4];
      int cl [4];
      bit ok [4];
      int mn = 1 << 30;
      int mx = -1;
      cv[0] = (x > 0) ? adjV[x-1] : 0;        cl[0] = (x > 0) ? adjL[x-1] : 0;
      cv[1] = adjV[x];                         cl[1] = adjL[x];
      cv[2] = (x < COLS-1) ? adjV[x+1] : 0;   cl[2] = (x < COLS-1) ? adjL[x+1] : 0;
      cv[3] = (x > 0) ? curV[x-1] : 0;        cl[3] = (x > 0) ? expL[x-1] : 0;
      ok[0] = adjOk && (x > 0);
      ok[1] = adjOk;
      ok[2] = adjOk && (x < COLS-1);
      ok[3] = (x > 0);
      for (int i = 0; i < 4; i++) begin
        if (ok[i] && cv[i] == curV[x] && cl[i] != 0) begin
          if (cl[i] < mn) mn = cl[i];
          if (cl[i] > mx) mx = cl[i];
        end
      end
      if (mx < 0) begin
        expL[x]  = (pass == 0) ? ((r + 1) * COLS + x + 1) : lkp[x];
        expEq[x] = 0;
        expTag[x] = (pass == 0) ? "R4" : "R5";
      end else begin
        expL[x]  = mn;
        expEq[x] = (mx != mn) ? 1 : 0;
        expTag[x] = "R6";
      end
      expO[x] = mx;
      expN[x] = mn;
      if (x == 0 || x == COLS-1) expTag[x] = "R8";
      if (!adjOk) expTag[x] = "R9";
    end
  endfunction

  // Streams one row; the adjacent stream leads the pixel stream by two columns.
  // rowIndex/passSel carry wrong values except on the rowStart cycle (R10).
  task automatic runRow(input int pass, input int r, input string tag);
    model(pass, r);
    for (int k = 0; k <= COLS + 2; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        int p = k - 3;
        string t = (tag != "") ? tag : expTag[p];
        check("R2 outValid", int'(outValid), 1);
        check({t, " label"}, int'(outLabel), expL[p]);
        check("R7 eqValid", int'(eqValid), expEq[p]);
        if (expEq[p] != 0) begin
          check("R7 eqOld", int'(eqOld), expO[p]);
          check("R7 eqNew", int'(eqNew), expN[p]);
        end
      end
      if (k <= COLS + 1) begin
        int p = k - 2;
        adjValue = (k < COLS) ? VAL_W'(adjV[k]) : '1;
        adjLabel = (k < COLS) ? LABEL_W'(adjL[k]) : 8'd3;
        pixValid = (p >= 0);
        rowStart = (p == 0);
        rowIndex = (p == 0) ? 3'(r) : 3'(ROWS - 1 - r);
        passSel  = (p == 0) ? pass[0] : ~pass[0];
        pixValue = (p >= 0) ? VAL_W'(curV[p]) : '0;
        lookupLabel = (p >= 0) ? LABEL_W'(lkp[p]) : '0;
      end else begin
        pixValid = 1'b0;
        rowStart = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 idle outValid", int'(outValid), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; rowStart = 1'b0; rowIndex = '0; passSel = 1'b0;
    adjValue = '0; adjLabel = '0; pixValid = 1'b0; pixValue = '0; lookupLabel = '0;
    repeat (3) @(negedge clk);
    check("R1 outValid", int'(outValid), 0);
    check("R1 eqValid", int'(eqValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after release", int'(outValid), 0);

    // R3: same-valued adjacent row with zero labels; different-valued labelled cells.
    for (int x = 0; x < COLS; x++) begin
      adjV[x] = 5; adjL[x] = 0; curV[x] = (x < 4) ? 5 : 6; lkp[x] = 1;
    end
    adjV[6] = 9; adjL[6] = 2;
    runRow(0, 3, "R3");

    // R7: descending adjacent labels on equal values force a merge per pixel.
    for (int x = 0; x < COLS; x++) begin
      adjV[x] = 1; adjL[x] = 40 - 3 * x; curV[x] = 1; lkp[x] = 7;
    end
    runRow(0, 2, "R7");

    // R10: no matches at all; fresh labels reveal captured row and pass.
    for (int x = 0; x < COLS; x++) begin
      adjV[x] = 15; adjL[x] = 9; curV[x] = x; lkp[x] = 50 + x;
    end
    runRow(0, 5, "R10");
    runRow(1, 5, "R10");

    for (int pass = 0; pass < 2; pass++) begin
      for (int ri = 0; ri < 4; ri++) begin
        int r = (ri == 0) ? 0 : (ri == 1) ? 3 : (ri == 2) ? 4 : ROWS - 1;
        for (int pat = 0; pat < 8; pat++) begin
          for (int x = 0; x < COLS; x++) begin
            case (pat)
              0: begin curV[x] = 2; adjV[x] = 2; adjL[x] = (x + 1) * 3; end
              1: begin curV[x] = 1; adjV[x] = 2; adjL[x] = x + 1; end
              default: begin
                curV[x] = rnd(3); adjV[x] = rnd(3); adjL[x] = rnd(10);
              end
            endcase
            lkp[x] = rnd(40) + 1;
          end
          runRow(pass, r, "");
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule